// File: doc/BRIEF.md
# Boot Alias Selector and Code-Window Decoder

This block decides which memory answers in the low code window of the address map after a reset. Two strap pins are sampled on a fixed clock edge after reset is released, and again on a fixed edge after each standby exit. The sampled code picks one of three targets to overlay the low window: main flash, the system (loader) memory, or the on-chip SRAM. The first fetch reads the stack value at address 0x00000000. Execution then begins at 0x00000004, and both land inside the chosen memory.

Later, software can move the overlay by writing a two-bit remap code. The same capture event loads that code from the straps. Accesses in the low window are translated to the chosen memory's native address. An offset past the end of that memory raises a decode error instead. All three memories also stay reachable at their native addresses, whatever alias is active. The outputs are one select line per memory, the translated address, a ready-to-fetch flag and the error flag.

Top module: `boot_alias_map`

## Requirements
- R1: After reset is released, `fetch_ready` stays low through the first three rising clock edges and goes high on the fourth, which is also the edge that samples the straps. While `fetch_ready` is low, no select line and no decode error is asserted.
- R2: A strap code with `boot_sel_lo`=0 selects flash as the alias, whatever the value of `boot_sel_hi`.
- R3: A strap code with `boot_sel_hi`=0 and `boot_sel_lo`=1 selects system memory as the alias.
- R4: A strap code with `boot_sel_hi`=1 and `boot_sel_lo`=1 selects SRAM as the alias.
- R5: A clock edge with `standby_exit` high drops `fetch_ready`. The straps are sampled again on the fourth rising edge after that edge, and `fetch_ready` then rises.
- R6: Strap changes after the sampling edge have no effect on the alias until the next reset or standby exit.
- R7: The native windows always decode with `tgt_addr` equal to `bus_addr`, regardless of the alias:
  - flash: 0x08000000, 1 MiB
  - system memory: 0x1FFF0000, 0x7800 bytes
  - SRAM: 0x20000000, 256 KiB

  Any address outside these windows and outside the low window asserts nothing.
- R8: An address in the low window (below 0x08000000) that lies inside the alias memory's size selects that memory, with `tgt_addr` = memory base + `bus_addr`. Addresses 0 and 4 map to base and base+4.
- R9: A low-window address at or beyond the alias memory's size raises `decode_err`, and no select line is asserted.
- R10: A `remap_we` pulse while `fetch_ready` is high loads `remap_code`, using the strap encoding, and the new alias applies from the next cycle. A write in the same cycle as the sampling edge, or in a cycle with `standby_exit` high, is dropped.
- R11: At most one select line is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_exit | input | 1 | Restart of the strap sampling sequence |
| boot_sel_lo | input | 1 | Strap pin, low bit of the boot code |
| boot_sel_hi | input | 1 | Strap pin, high bit of the boot code |
| remap_we | input | 1 | Remap register write strobe |
| remap_code | input | 2 | Remap code {hi, lo}, same encoding as the straps |
| bus_addr | input | 32 | Code-area access address |
| sel_flash | output | 1 | Access goes to flash |
| sel_sysmem | output | 1 | Access goes to system memory |
| sel_sram | output | 1 | Access goes to SRAM |
| tgt_addr | output | 32 | Native address at the selected memory |
| fetch_ready | output | 1 | Straps have been sampled; fetching may start |
| decode_err | output | 1 | Low-window address beyond the alias memory size |

## Verification
Two register updates can fall on the same clock edge. The strap sampling edge can coincide with a software remap write, and a standby exit can coincide with a write. The bench raises `remap_we` with an SRAM code during the cycle that ends in the fourth edge after a standby exit, while the straps select system memory. A correct design shows system memory at address 0 afterwards. A second write, issued while ready, then proves that the write path itself works.

// File: rtl/boot_map_pkg.sv
package boot_map_pkg;

   typedef enum logic [1:0] {
      TGT_FLASH = 2'd0,
      TGT_SYS   = 2'd1,
      TGT_SRAM  = 2'd2
   } tgt_e;

   localparam int NUM_TGT = 3;

   // code is {hi, lo}; lo = 0 always means flash
   function automatic tgt_e code_to_tgt(input logic [1:0] code);
      if (!code[0])      return TGT_FLASH;
      else if (!code[1]) return TGT_SYS;
      else               return TGT_SRAM;
   endfunction

endpackage

// File: rtl/boot_strap_sampler.sv
module boot_strap_sampler #(
   parameter int CAP_EDGE = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       standby_exit,
   input  logic [1:0] pins,
   output logic       ready,
   output logic       cap_fire,
   output logic [1:0] cap_code
);

   initial begin
      assert (CAP_EDGE >= 1) else $error("CAP_EDGE must be at least 1");
   end

   logic ready_q;

   generate
      if (CAP_EDGE == 1) begin : g_direct
         assign cap_fire = !standby_exit && !ready_q;
      end else begin : g_count
         localparam int CNT_W = $clog2(CAP_EDGE);
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             cnt_q <= '0;
            else if (standby_exit)  cnt_q <= '0;
            else if (!ready_q)      cnt_q <= cnt_q + 1'b1;
         end
         assign cap_fire = !standby_exit && !ready_q &&
                           (cnt_q == CNT_W'(CAP_EDGE - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            ready_q <= 1'b0;
      else if (standby_exit) ready_q <= 1'b0;
      else if (cap_fire)     ready_q <= 1'b1;
   end

   assign ready    = ready_q;
   assign cap_code = pins;

   AST_EXIT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      standby_exit |=> !ready); // R5
   AST_READY_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !standby_exit) |=> ready); // R6
   AST_FIRE_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      cap_fire |=> ready); // R1

endmodule

// File: rtl/boot_alias_reg.sv
module boot_alias_reg
   import boot_map_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ready,
   input  logic       standby_exit,
   input  logic       cap_fire,
   input  logic [1:0] cap_code,
   input  logic       wr_en,
   input  logic [1:0] wr_code,
   output tgt_e       alias_tgt
);

   tgt_e alias_q;
   logic wr_ok;

   assign wr_ok = wr_en && ready && !standby_exit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        alias_q <= TGT_FLASH;
      else if (cap_fire) alias_q <= code_to_tgt(cap_code);
      else if (wr_ok)    alias_q <= code_to_tgt(wr_code);
   end

   assign alias_tgt = alias_q;

   AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      cap_fire |=> (alias_tgt == code_to_tgt($past(cap_code)))); // R10
   AST_ALIAS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap_fire && !(wr_en && ready)) |=> $stable(alias_tgt)); // R6

endmodule

// File: rtl/boot_addr_decode.sv
module boot_addr_decode
   import boot_map_pkg::*;
#(
   parameter int                ADDR_W       = 32,
   parameter logic [ADDR_W-1:0] LOW_WIN_SIZE = 32'h0800_0000,
   parameter logic [ADDR_W-1:0] FLASH_BASE   = 32'h0800_0000,
   parameter logic [ADDR_W-1:0] FLASH_SIZE   = 32'h0010_0000,
   parameter logic [ADDR_W-1:0] SYS_BASE     = 32'h1FFF_0000,
   parameter logic [ADDR_W-1:0] SYS_SIZE     = 32'h0000_7800,
   parameter logic [ADDR_W-1:0] SRAM_BASE    = 32'h2000_0000,
   parameter logic [ADDR_W-1:0] SRAM_SIZE    = 32'h0004_0000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ready,
   input  tgt_e               alias_tgt,
   input  logic [ADDR_W-1:0]  addr,
   output logic [NUM_TGT-1:0] sel,
   output logic [ADDR_W-1:0]  tgt_addr,
   output logic               err
);

   localparam logic [ADDR_W-1:0] BASES [NUM_TGT] = '{FLASH_BASE, SYS_BASE, SRAM_BASE};
   localparam logic [ADDR_W-1:0] SIZES [NUM_TGT] = '{FLASH_SIZE, SYS_SIZE, SRAM_SIZE};

   initial begin
      assert (FLASH_SIZE <= LOW_WIN_SIZE && SYS_SIZE <= LOW_WIN_SIZE &&
              SRAM_SIZE <= LOW_WIN_SIZE) else $error("memory larger than low window");
      assert (FLASH_BASE >= LOW_WIN_SIZE && SYS_BASE >= LOW_WIN_SIZE &&
              SRAM_BASE >= LOW_WIN_SIZE) else $error("native window overlaps low window");
   end

   logic [NUM_TGT-1:0] native_hit;

   genvar g;
   generate
      for (g = 0; g < NUM_TGT; g++) begin : g_native
         assign native_hit[g] = (addr >= BASES[g]) &&
            ({1'b0, addr} < ({1'b0, BASES[g]} + {1'b0, SIZES[g]}));
      end
   endgenerate

   logic [ADDR_W-1:0]  a_base, a_size;
   logic [NUM_TGT-1:0] a_onehot;

   always_comb begin
      case (alias_tgt)
         TGT_SYS:  begin a_base = SYS_BASE;   a_size = SYS_SIZE;   a_onehot = 3'b010; end
         TGT_SRAM: begin a_base = SRAM_BASE;  a_size = SRAM_SIZE;  a_onehot = 3'b100; end
         default:  begin a_base = FLASH_BASE; a_size = FLASH_SIZE; a_onehot = 3'b001; end
      endcase
   end

   always_comb begin
      sel      = '0;
      err      = 1'b0;
      tgt_addr = addr;
      if (ready) begin
         if (addr < LOW_WIN_SIZE) begin
            if (addr < a_size) begin
               sel      = a_onehot;
               tgt_addr = a_base + addr;
            end else begin
               err = 1'b1;
            end
         end else begin
            sel = native_hit;
         end
      end
   end

   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel)); // R11
   AST_ERR_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (sel == '0)); // R9
   AST_IDLE_BEFORE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> (sel == '0 && !err)); // R1

endmodule

// File: rtl/boot_alias_map.sv
module boot_alias_map
   import boot_map_pkg::*;
#(
   parameter int CAP_EDGE = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        standby_exit,
   input  logic        boot_sel_lo,
   input  logic        boot_sel_hi,
   input  logic        remap_we,
   input  logic [1:0]  remap_code,
   input  logic [31:0] bus_addr,
   output logic        sel_flash,
   output logic        sel_sysmem,
   output logic        sel_sram,
   output logic [31:0] tgt_addr,
   output logic        fetch_ready,
   output logic        decode_err
);

   logic               ready;
   logic               cap_fire;
   logic [1:0]         cap_code;
   tgt_e               alias_tgt;
   logic [NUM_TGT-1:0] sel;

   boot_strap_sampler #(.CAP_EDGE(CAP_EDGE)) i_sampler (
      .clk          (clk),
      .rst_n        (rst_n),
      .standby_exit (standby_exit),
      .pins         ({boot_sel_hi, boot_sel_lo}),
      .ready        (ready),
      .cap_fire     (cap_fire),
      .cap_code     (cap_code)
   );

   boot_alias_reg i_alias (
      .clk          (clk),
      .rst_n        (rst_n),
      .ready        (ready),
      .standby_exit (standby_exit),
      .cap_fire     (cap_fire),
      .cap_code     (cap_code),
      .wr_en        (remap_we),
      .wr_code      (remap_code),
      .alias_tgt    (alias_tgt)
   );

   boot_addr_decode #(.ADDR_W(32)) i_decode (
      .clk       (clk),
      .rst_n     (rst_n),
      .ready     (ready),
      .alias_tgt (alias_tgt),
      .addr      (bus_addr),
      .sel       (sel),
      .tgt_addr  (tgt_addr),
      .err       (decode_err)
   );

   assign sel_flash   = sel[0];
   assign sel_sysmem  = sel[1];
   assign sel_sram    = sel[2];
   assign fetch_ready = ready;

endmodule

// File: tb/test_boot_alias_map.sv
module test_boot_alias_map;

   localparam int CLK_PERIOD = 10;
   localparam int NV = 17;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        standby_exit = 1'b0;
   logic        boot_sel_lo = 1'b0;
   logic        boot_sel_hi = 1'b0;
   logic        remap_we = 1'b0;
   logic [1:0]  remap_code = 2'b00;
   logic [31:0] bus_addr = 32'h0;
   logic        sel_flash, sel_sysmem, sel_sram, fetch_ready, decode_err;
   logic [31:0] tgt_addr;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   boot_alias_map i_boot_alias_map (
      .clk(clk), .rst_n(rst_n), .standby_exit(standby_exit),
      .boot_sel_lo(boot_sel_lo), .boot_sel_hi(boot_sel_hi),
      .remap_we(remap_we), .remap_code(remap_code), .bus_addr(bus_addr),
      .sel_flash(sel_flash), .sel_sysmem(sel_sysmem), .sel_sram(sel_sram),
      .tgt_addr(tgt_addr), .fetch_ready(fetch_ready), .decode_err(decode_err)
   );

   // {pins{hi,lo}, addr, sel{sram,sys,flash}, tgt, err, req}
   localparam logic [73:0] VEC [NV] = '{
      {2'b00, 32'h0000_0000, 3'b001, 32'h0800_0000, 1'b0, 4'd2},  // R2 stack word
      {2'b00, 32'h0000_0004, 3'b001, 32'h0800_0004, 1'b0, 4'd8},  // R8 entry word
      {2'b00, 32'h000F_FFFC, 3'b001, 32'h080F_FFFC, 1'b0, 4'd8},  // R8 last flash word
      {2'b00, 32'h0010_0000, 3'b000, 32'h0,         1'b1, 4'd9},  // R9 past flash
      {2'b10, 32'h0000_0100, 3'b001, 32'h0800_0100, 1'b0, 4'd2},  // R2 hi ignored
      {2'b01, 32'h0000_0000, 3'b010, 32'h1FFF_0000, 1'b0, 4'd3},  // R3
      {2'b01, 32'h0000_77FC, 3'b010, 32'h1FFF_77FC, 1'b0, 4'd8},  // R8
      {2'b01, 32'h0000_7800, 3'b000, 32'h0,         1'b1, 4'd9},  // R9 past sysmem
      {2'b11, 32'h0000_0004, 3'b100, 32'h2000_0004, 1'b0, 4'd4},  // R4
      {2'b11, 32'h0003_FFFC, 3'b100, 32'h2003_FFFC, 1'b0, 4'd8},  // R8
      {2'b11, 32'h0004_0000, 3'b000, 32'h0,         1'b1, 4'd9},  // R9 past sram
      {2'b11, 32'h0800_0010, 3'b001, 32'h0800_0010, 1'b0, 4'd7},  // R7 native flash
      {2'b11, 32'h1FFF_0020, 3'b010, 32'h1FFF_0020, 1'b0, 4'd7},  // R7 native sysmem
      {2'b00, 32'h2000_0040, 3'b100, 32'h2000_0040, 1'b0, 4'd7},  // R7 native sram
      {2'b00, 32'h0810_0000, 3'b000, 32'h0,         1'b0, 4'd7},  // R7 past flash native
      {2'b01, 32'h1FFF_7800, 3'b000, 32'h0,         1'b0, 4'd7},  // R7 past sysmem native
      {2'b11, 32'h4000_0000, 3'b000, 32'h0,         1'b0, 4'd7}   // R7 unmapped
   };

   task automatic check_out(input string req, input logic [2:0] es,
                            input logic [31:0] et, input logic ee);
      logic [2:0] got;
      got = {sel_sram, sel_sysmem, sel_flash};
      n_tests++;
      if (got !== es || decode_err !== ee || (es != 3'b000 && tgt_addr !== et)) begin
         n_fail++;
         $display("FAIL %s addr=%h: sel=%b tgt=%h err=%b expected sel=%b tgt=%h err=%b",
                  req, bus_addr, got, tgt_addr, decode_err, es, et, ee);
      end
   endtask

   task automatic check_bit(input string req, input logic got, input logic exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b", req, got, exp);
      end
   endtask

   // standby exit with given straps; returns at negedge after the sampling edge
   task automatic restart(input logic [1:0] pins);
      @(negedge clk);
      {boot_sel_hi, boot_sel_lo} = pins;
      standby_exit = 1'b1;
      @(posedge clk);
      @(negedge clk);
      standby_exit = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      // reset state, R1
      #(CLK_PERIOD * 3);
      @(negedge clk);
      bus_addr = 32'h0;
      #1;
      check_bit("R1 ready in reset", fetch_ready, 1'b0);
      check_out("R1 quiet in reset", 3'b000, 32'h0, 1'b0);

      // R1 sampling on the fourth edge, straps select system memory
      {boot_sel_hi, boot_sel_lo} = 2'b01;
      rst_n = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_bit("R1 ready after 3 edges", fetch_ready, 1'b0);
      check_out("R1 no select before ready", 3'b000, 32'h0, 1'b0);
      @(posedge clk);
      @(negedge clk);
      check_bit("R1 ready after 4 edges", fetch_ready, 1'b1);
      #1;
      check_out("R3 alias after reset", 3'b010, 32'h1FFF_0000, 1'b0);

      // R6 strap change after sampling
      {boot_sel_hi, boot_sel_lo} = 2'b11;
      repeat (5) @(posedge clk);
      @(negedge clk);
      check_out("R6 straps ignored", 3'b010, 32'h1FFF_0000, 1'b0);

      // R5 standby restart timing
      standby_exit = 1'b1;
      @(posedge clk);
      @(negedge clk);
      standby_exit = 1'b0;
      check_bit("R5 ready drops", fetch_ready, 1'b0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_bit("R5 ready low after 3 edges", fetch_ready, 1'b0);
      @(posedge clk);
      @(negedge clk);
      check_bit("R5 ready after 4 edges", fetch_ready, 1'b1);
      bus_addr = 32'h0;
      #1;
      check_out("R5 resampled to sram", 3'b100, 32'h2000_0000, 1'b0);

      // vector table
      for (int i = 0; i < NV; i++) begin
         restart(VEC[i][73:72]);
         bus_addr = VEC[i][71:40];
         #1;
         check_out($sformatf("R%0d vec%0d", VEC[i][3:0], i),
                   VEC[i][39:37], VEC[i][36:5], VEC[i][4]);
      end

      // R10 write on the sampling edge is dropped
      @(negedge clk);
      {boot_sel_hi, boot_sel_lo} = 2'b01;
      standby_exit = 1'b1;
      @(posedge clk);
      @(negedge clk);
      standby_exit = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      remap_we = 1'b1;
      remap_code = 2'b11;
      @(posedge clk);
      @(negedge clk);
      remap_we = 1'b0;
      bus_addr = 32'h0;
      #1;
      check_out("R10 capture beats write", 3'b010, 32'h1FFF_0000, 1'b0);

      // R10 write while ready
      @(negedge clk);
      remap_we = 1'b1;
      remap_code = 2'b11;
      @(posedge clk);
      @(negedge clk);
      remap_we = 1'b0;
      #1;
      check_out("R10 remap to sram", 3'b100, 32'h2000_0000, 1'b0);
      @(negedge clk);
      remap_we = 1'b1;
      remap_code = 2'b10;
      @(posedge clk);
      @(negedge clk);
      remap_we = 1'b0;
      bus_addr = 32'h4;
      #1;
      check_out("R10 remap code 10 to flash", 3'b001, 32'h0800_0004, 1'b0);

      finish_run();
   end

endmodule